// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the address for a four-beat memory burst. A start strobe captures a full address. The upper bits are held unchanged for the whole burst. The two low bits become the offset where the burst begins. The block then steps a private beat index on each clock edge that sees the active-low advance input low. The low address bits follow one of two orders, chosen by a mode input: an interleaved order (offset XOR beat) or a linear order (offset plus beat, modulo the burst length).

A start strobe wins over the advance input on the same edge. When neither the strobe nor an advance is present, the burst is suspended and the address holds. After the last beat the index wraps, so the address returns to the loaded offset. A flag marks the final beat of the burst. A memory controller can use this flag to schedule the next burst start without decoding the address.

Top module: `bseq_burst_addr`

## Requirements
- R1: A synchronous active-high reset drives `addr_out` to all zeros and `last_beat` to 0 on the following edge.
- R2: On an edge with `burst_start` high, `addr_out` after that edge equals `addr_in` exactly, in both modes (beat index 0).
- R3: With `interleave` high, the low two bits of `addr_out` on beat k equal the loaded offset XOR k (for example, offset 01 gives 01, 00, 11, 10).
- R4: With `interleave` low, the low two bits of `addr_out` on beat k equal (loaded offset + k) mod 4 (for example, offset 01 gives 01, 10, 11, 00).
- R5: The beat index moves forward only on an edge where `adv_n` is low and `burst_start` is low. With `adv_n` high and no start, `addr_out` and `last_beat` hold.
- R6: On an edge with `burst_start` high, `adv_n` is ignored: the next beat is 0 whether `adv_n` is high or low.
- R7: An advance from beat 3 wraps the index to beat 0, and the low address bits return to the loaded offset.
- R8: `last_beat` is 1 exactly when the beat index is 3, in either mode and for any offset.
- R9: The bits of `addr_out` above the low two keep the value loaded at the last start for the whole burst, through advances, holds and wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_start | input | 1 | Load strobe; starts a burst from `addr_in` |
| adv_n | input | 1 | Active-low advance; steps the beat index |
| interleave | input | 1 | 1 selects interleaved order, 0 selects linear order |
| addr_in | input | ADDR_W | Burst start address |
| addr_out | output | ADDR_W | Current burst address |
| last_beat | output | 1 | High on the final beat of the burst |

## Verification
The bench sweeps every start offset in both orders. It mixes advances with suspended cycles, so a design that steps on a high `adv_n` would shift every later address. It places starts with `adv_n` both low and high: a design that lets the advance act on a start edge would begin on the second beat and report the flag one beat early. Each burst runs past the fourth beat, which exposes a counter that saturates or jumps to zero instead of returning to the loaded offset. Linear runs from offsets 2 and 3 catch a carry that leaks into the upper address bits.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        BEAT_HOLD = 2'd0,
        BEAT_STEP = 2'd1,
        BEAT_LOAD = 2'd2
    } beat_cmd_e;

    function automatic beat_cmd_e decode_cmd(input logic start, input logic adv_n);
        if (start)
            return BEAT_LOAD;
        else if (!adv_n)
            return BEAT_STEP;
        else
            return BEAT_HOLD;
    endfunction

endpackage

// File: rtl/bseq_load_reg.sv
module bseq_load_reg #(
    parameter int ADDR_W = 8,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] held_addr
);
    always_ff @(posedge clk) begin
        if (rst)
            held_addr <= '0;
        else if (load)
            held_addr <= addr_in;
    end

    // R9: the upper bits move only on a load
    assert_upper_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(held_addr[ADDR_W-1:BEAT_W]));
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
    import bseq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_cmd_e         cmd,
    output logic [BEAT_W-1:0] beat,
    output logic              last
);
    localparam logic [BEAT_W-1:0] LAST_IDX = {BEAT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            beat <= '0;
        else begin
            case (cmd)
                BEAT_LOAD: beat <= '0;
                BEAT_STEP: beat <= beat + 1'b1;
                default:   beat <= beat;
            endcase
        end
    end

    assign last = (beat == LAST_IDX);

    // R5: a hold command leaves the index alone
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == BEAT_HOLD) |=> $stable(beat));
    // R6: a load always lands on beat zero
    assert_load_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd == BEAT_LOAD) |=> (beat == '0) && !last);
    // R7: stepping from the final beat wraps to zero
    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == BEAT_STEP && last) |=> (beat == '0));
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
    import bseq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] offset,
    input  logic [BEAT_W-1:0] beat,
    input  order_e            order,
    output logic [BEAT_W-1:0] low_addr
);
    logic [BEAT_W-1:0] xor_addr;
    logic [BEAT_W-1:0] sum_addr;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign xor_addr[b] = offset[b] ^ beat[b];
    end

    assign sum_addr = offset + beat;

    always_comb begin
        if (order == ORDER_INTERLEAVED)
            low_addr = xor_addr;
        else
            low_addr = sum_addr;
    end
endmodule

// File: rtl/bseq_burst_addr.sv
module bseq_burst_addr
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_start,
    input  logic              adv_n,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              last_beat
);
    beat_cmd_e         cmd;
    logic [ADDR_W-1:0] held_addr;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low_addr;
    order_e            order;

    assign cmd   = decode_cmd(burst_start, adv_n);
    assign order = interleave ? ORDER_INTERLEAVED : ORDER_LINEAR;

    bseq_load_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_load (
        .clk(clk), .rst(rst), .load(burst_start),
        .addr_in(addr_in), .held_addr(held_addr)
    );

    bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk(clk), .rst(rst), .cmd(cmd), .beat(beat), .last(last_beat)
    );

    bseq_order_map #(.BEAT_W(BEAT_W)) u_map (
        .offset(held_addr[BEAT_W-1:0]), .beat(beat),
        .order(order), .low_addr(low_addr)
    );

    assign addr_out = {held_addr[ADDR_W-1:BEAT_W], low_addr};

    // R2: the cycle after a start presents the captured address
    assert_start_addr_R2: assert property (@(posedge clk) disable iff (rst)
        burst_start |=> (addr_out == $past(addr_in)));
    // R1: reset clears the visible outputs
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (addr_out == '0) && !last_beat);
    // R8: the flag and a step from it are followed by a non-final beat
    assert_flag_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (last_beat && !burst_start && !adv_n) |=> !last_beat);
endmodule

// File: tb/tb_bseq_burst_addr.sv
module tb_bseq_burst_addr;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          burst_start;
    logic          adv_n;
    logic          interleave;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic          last_beat;

    int n_cmp = 0;
    int n_bad = 0;

    int          m_k;
    logic [1:0]  m_off;
    logic [5:0]  m_up;

    always #2 clk = ~clk;

    bseq_burst_addr #(.ADDR_W(AW), .BEAT_W(2)) dut (
        .clk(clk), .rst(rst), .burst_start(burst_start), .adv_n(adv_n),
        .interleave(interleave), .addr_in(addr_in),
        .addr_out(addr_out), .last_beat(last_beat)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_low(input logic [1:0] off, input int k, input logic il);
        logic [1:0] kk;
        kk = k[1:0];
        return il ? (off ^ kk) : ((off + kk) & 2'b11);
    endfunction

    // drive one edge, update the reference, then compare 1 ns after the edge
    task automatic tick(input logic st, input logic an, input logic [AW-1:0] a);
        string tag;
        @(negedge clk);
        burst_start = st;
        adv_n       = an;
        addr_in     = a;
        @(posedge clk);
        if (st) begin
            m_off = a[1:0];
            m_up  = a[AW-1:2];
            m_k   = 0;
            tag   = an ? "R2" : "R6";
        end else if (!an) begin
            m_k = (m_k + 1) % 4;
            if (m_k == 0) tag = "R7";
            else          tag = interleave ? "R3" : "R4";
        end else begin
            tag = "R5";
        end
        #1;
        check(tag, addr_out[1:0], exp_low(m_off, m_k, interleave));
        check("R9", addr_out[AW-1:2], m_up);
        check("R8", last_beat, (m_k == 3));
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; burst_start = 1'b0; adv_n = 1'b1; interleave = 1'b0; addr_in = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", addr_out, 0);
        check("R1", last_beat, 0);
        @(negedge clk);
        rst = 1'b0;
        m_k = 0; m_off = 2'b00; m_up = '0;

        for (int il = 0; il < 2; il++) begin
            for (int off = 0; off < 4; off++) begin
                logic [AW-1:0] a;
                interleave = il[0];
                a = AW'((off * 37 + il * 90 + 5) & 8'hFC) | AW'(off);
                tick(1'b1, off[0], a);
                for (int i = 0; i < 11; i++)
                    tick(1'b0, (i % 3 == 1), ~a);
            end
        end

        // explicit sequences named in the requirements
        interleave = 1'b1;
        tick(1'b1, 1'b1, 8'h41);
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 8'h00);
        interleave = 1'b0;
        tick(1'b1, 1'b0, 8'h81);
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 8'h00);

        // restart in the middle of a burst
        tick(1'b0, 1'b0, 8'h00);
        tick(1'b1, 1'b0, 8'hF3);
        tick(1'b0, 1'b1, 8'h00);
        tick(1'b0, 1'b0, 8'h00);

        // reset in the middle of a burst
        @(negedge clk);
        rst = 1'b1; burst_start = 1'b0; adv_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", addr_out, 0);
        check("R1", last_beat, 0);
        @(negedge clk);
        rst = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule